// File: doc/BRIEF.md
# Burst Address Sequencer With Selectable Order

This block produces the address for each beat of a four-beat burst on a synchronous memory port. The controller presents one full address with the advance/load control low. The sequencer captures that address and sends it out as the first beat. On each later qualified rising edge with advance/load high, it steps to the next beat. Only the two least-significant address bits change during a burst. The upper bits are held exactly as they were loaded.

A static order-select input picks the beat order. Low gives a linear order that counts upward and wraps modulo four. High, which is also the level to use when the input is left floating at board level, gives an interleaved order in which each beat's low bits are the start value XORed with the beat number. A stall input, active high, inserts a wait state: nothing is captured or advanced on that edge. A flag marks the fourth beat. Advancing past the fourth beat wraps back to the first beat of the same burst.

Control is a small state machine with states `ST_IDLE`, `ST_B0`, `ST_B1`, `ST_B2` and `ST_B3`. The transitions are:
- `LOAD`: any state goes to `ST_B0` when advance is low.
- `STEP`: each `ST_Bn` goes to `ST_Bn+1` when advance is high.
- `WRAP`: `ST_B3` goes to `ST_B0` when advance is high.
- `IDLE_HOLD`: `ST_IDLE` stays in `ST_IDLE` when advance is high.
- `STALL`: any state holds its value when stall is high.

Top module: `bas_burst_seq`

## Requirements
- R1: While synchronous reset `rst` is high on a rising edge, the sequencer returns to `ST_IDLE`. `cur_addr` then reads all zeros and `last_beat` reads 0.
- R2: On a rising edge with `stall`=0 and `advance`=0, the sequencer loads `ext_addr`. From the next cycle, `cur_addr` equals the loaded address and `last_beat` is 0. This is beat 0.
- R3: With `order_sel`=0 (linear), beat k of a burst that started at low bits s has `cur_addr[1:0]` = (s + k) mod 4.
- R4: With `order_sel`=1 (interleaved), beat k of a burst that started at low bits s has `cur_addr[1:0]` = s XOR k.
- R5: During advance cycles, `cur_addr[ADDR_W-1:2]` keeps the loaded upper bits, and `ext_addr` is ignored.
- R6: `last_beat` is 1 exactly when the burst is on beat 3, the fourth beat. It is 0 on beats 0 to 2.
- R7: An advance edge taken on beat 3 returns the burst to beat 0. At that point `cur_addr` equals the loaded address again and `last_beat` is 0.
- R8: On a rising edge with `stall`=1, `cur_addr` and `last_beat` keep their values, whatever `advance` and `ext_addr` are doing. A load requested on that edge is ignored.
- R9: An advance edge taken in `ST_IDLE`, before any load since reset, leaves `cur_addr` at zero and `last_beat` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Wait state when high; all state holds |
| advance | input | 1 | 0 loads `ext_addr`, 1 steps the burst |
| order_sel | input | 1 | Static beat order: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | Address captured on a load edge |
| cur_addr | output | ADDR_W | Address of the current beat |
| last_beat | output | 1 | High on the fourth beat of the burst |

## Verification
The bench runs every start value in both orders through more than a full burst, so it covers the fourth beat and the wrap that follows. A linear/interleaved mix-up shows up on start values 01 and 11 at beats 1 and 3. A wrap that lands on a stray value instead of the start shows up on the beat after the flag. The bench inserts stalls that request a load with a different address, to catch a design that honours a load or steps while stalled. It also changes `ext_addr` during advance cycles, to catch upper bits that leak through from the input instead of being held. A final case advances straight out of reset, to catch an idle state that starts counting a burst that was never loaded.

// File: rtl/bas_pkg.sv
package bas_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_B0   = 3'd1,
        ST_B1   = 3'd2,
        ST_B2   = 3'd3,
        ST_B3   = 3'd4
    } bas_state_e;

    localparam int unsigned BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

endpackage

// File: rtl/bas_fsm.sv
module bas_fsm
    import bas_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stall,
    input  logic       advance,
    output bas_state_e state,
    output beat_t      beat,
    output logic       load_en,
    output logic       last
);

    bas_state_e nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        if (!stall) begin
            if (!advance) begin
                nxt = ST_B0;                  // LOAD
            end else begin
                unique case (state)
                    ST_IDLE: nxt = ST_IDLE;   // IDLE_HOLD
                    ST_B0:   nxt = ST_B1;     // STEP
                    ST_B1:   nxt = ST_B2;     // STEP
                    ST_B2:   nxt = ST_B3;     // STEP
                    ST_B3:   nxt = ST_B0;     // WRAP
                    default: nxt = ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        load_en = !stall && !advance;
        beat    = '0;
        last    = 1'b0;
        unique case (state)
            ST_IDLE: beat = 2'd0;
            ST_B0:   beat = 2'd0;
            ST_B1:   beat = 2'd1;
            ST_B2:   beat = 2'd2;
            ST_B3: begin
                beat = 2'd3;
                last = 1'b1;
            end
            default: beat = 2'd0;
        endcase
    end

    // R8: a stalled edge changes no state
    a_r8_stall_holds_state: assert property (@(posedge clk) disable iff (rst)
        stall |=> (state == $past(state)));

    // R6: the fourth beat is reached only by a step from the third
    a_r6_b3_from_b2: assert property (@(posedge clk) disable iff (rst)
        (!stall && advance && state == ST_B2) |=> (state == ST_B3));

    // R7: stepping from the fourth beat wraps to the first
    a_r7_wrap_to_b0: assert property (@(posedge clk) disable iff (rst)
        (!stall && advance && state == ST_B3) |=> (state == ST_B0));

    // R9: idle never starts a burst by itself
    a_r9_idle_stays: assert property (@(posedge clk) disable iff (rst)
        (advance && state == ST_IDLE) |=> (state == ST_IDLE));

endmodule

// File: rtl/bas_addr_reg.sv
module bas_addr_reg
    import bas_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    localparam int unsigned UP_W  = ADDR_W - BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [UP_W-1:0]   upper,
    output beat_t             start
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper <= '0;
            start <= '0;
        end else if (load_en) begin
            upper <= ext_addr[ADDR_W-1:BEAT_W];
            start <= ext_addr[BEAT_W-1:0];
        end
    end

    // R5: captured address changes only on a load edge
    a_r5_capture_only_on_load: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> ($stable(upper) && $stable(start)));

endmodule

// File: rtl/bas_order.sv
module bas_order
    import bas_pkg::*;
(
    input  beat_t start,
    input  beat_t beat,
    input  logic  order_sel,
    output beat_t low
);

    beat_t lin_low;
    beat_t ilv_low;

    always_comb begin
        lin_low = start + beat;
    end

    genvar gi;
    generate
        for (gi = 0; gi < BEAT_W; gi++) begin : g_ilv
            assign ilv_low[gi] = start[gi] ^ beat[gi];
        end
    endgenerate

    always_comb begin
        low = order_sel ? ilv_low : lin_low;
    end

    // R3/R4: beat 0 is always the start value in either order
    always_comb begin
        if (beat == '0) a_r3_beat0_is_start: assert (low == start);
    end

endmodule

// File: rtl/bas_burst_seq.sv
module bas_burst_seq
    import bas_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_beat
);

    localparam int unsigned UP_W = ADDR_W - BEAT_W;

    bas_state_e          state;
    beat_t               beat;
    beat_t               start;
    beat_t               low;
    logic                load_en;
    logic [UP_W-1:0]     upper;

    bas_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .advance (advance),
        .state   (state),
        .beat    (beat),
        .load_en (load_en),
        .last    (last_beat)
    );

    bas_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
        .clk      (clk),
        .rst      (rst),
        .load_en  (load_en),
        .ext_addr (ext_addr),
        .upper    (upper),
        .start    (start)
    );

    bas_order u_ord (
        .start     (start),
        .beat      (beat),
        .order_sel (order_sel),
        .low       (low)
    );

    assign cur_addr = {upper, low};

    // R2: a load edge presents the supplied address next cycle
    a_r2_load_presents_addr: assert property (@(posedge clk) disable iff (rst)
        (!stall && !advance) |=> (cur_addr == $past(ext_addr) && !last_beat));

    // R5: upper bits hold through advance cycles
    a_r5_upper_hold: assert property (@(posedge clk) disable iff (rst)
        advance |=> (cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])));

    // R7: flag clears after a step from the fourth beat
    a_r7_flag_clears: assert property (@(posedge clk) disable iff (rst)
        (!stall && advance && last_beat) |=> !last_beat);

    // R8: stalled edge keeps the outputs (order input assumed static)
    a_r8_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> ((cur_addr == $past(cur_addr) && last_beat == $past(last_beat))
                   || order_sel != $past(order_sel)));

    // R1: reset leaves a zero address and a clear flag
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (cur_addr == '0 && !last_beat));

endmodule

// File: tb/tb_bas_burst_seq.sv
module tb_bas_burst_seq;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall = 1'b0;
    logic          advance = 1'b1;
    logic          order_sel = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] cur_addr;
    logic          last_beat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    bit             m_loaded = 0;
    logic [AW-3:0]  m_up = '0;
    logic [1:0]     m_s = '0;
    logic [1:0]     m_k = '0;

    bas_burst_seq #(.ADDR_W(AW)) dut (
        .clk       (clk),
        .rst       (rst),
        .stall     (stall),
        .advance   (advance),
        .order_sel (order_sel),
        .ext_addr  (ext_addr),
        .cur_addr  (cur_addr),
        .last_beat (last_beat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] k,
                                           input logic sel);
        return sel ? (s ^ k) : 2'(s + k);
    endfunction

    task automatic step(input logic adv, input logic stl, input logic [AW-1:0] ea);
        string tag;
        logic [1:0] prev_k;
        @(negedge clk);
        advance  = adv;
        stall    = stl;
        ext_addr = ea;
        @(posedge clk);
        prev_k = m_k;
        if (stl)            tag = "R8";
        else if (!adv)      tag = "R2";
        else if (!m_loaded) tag = "R9";
        else if (prev_k == 2'd3) tag = "R7";
        else if (order_sel) tag = "R4";
        else                tag = "R3";
        if (!stl) begin
            if (!adv) begin
                m_loaded = 1;
                m_up = ea[AW-1:2];
                m_s  = ea[1:0];
                m_k  = 2'd0;
            end else if (m_loaded) begin
                m_k = m_k + 2'd1;
            end
        end
        #1;
        check({tag, " low bits"}, int'(cur_addr[1:0]),
              m_loaded ? int'(exp_low(m_s, m_k, order_sel)) : 0);
        check(adv && !stl && m_loaded ? "R5 upper bits" : {tag, " upper bits"},
              int'(cur_addr[AW-1:2]), int'(m_up));
        check(stl ? "R8 flag" : "R6 flag", int'(last_beat),
              (m_loaded && m_k == 2'd3) ? 1 : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 addr", int'(cur_addr), 0);
        check("R1 flag", int'(last_beat), 0);
        @(negedge clk);
        rst = 1'b0;

        // R9: advance straight out of reset
        step(1'b1, 1'b0, 6'h2D);
        step(1'b1, 1'b0, 6'h13);

        for (int sel = 0; sel < 2; sel++) begin
            order_sel = 1'(sel);
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 3; u++) begin
                    logic [AW-3:0] up;
                    up = (u == 0) ? 4'h0 : (u == 1) ? 4'hA : 4'hF;
                    step(1'b0, 1'b0, {up, 2'(s)});
                    for (int b = 0; b < 6; b++) begin
                        if (b == 2) begin
                            // R8: stalled load with a different address is ignored
                            step(1'b0, 1'b1, {~up, 2'(s + 1)});
                            step(1'b1, 1'b1, {~up, 2'(s + 2)});
                        end
                        // R5: ext_addr varies while advancing
                        step(1'b1, 1'b0, {4'(b * 5), 2'(b)});
                    end
                end
            end
        end

        // R1: reset in mid-burst clears again
        step(1'b0, 1'b0, 6'h37);
        step(1'b1, 1'b0, 6'h00);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 addr after mid-burst reset", int'(cur_addr), 0);
        check("R1 flag after mid-burst reset", int'(last_beat), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule